// File: doc/BRIEF.md
# Serial Port Buffer with Hardware Flow Control

This block sits between the byte strobes of an asynchronous serial receiver and transmitter and a host. Arriving bytes are queued in a receive FIFO, and the host reads them at its own pace. Bytes the host writes are queued in a transmit FIFO. Each queued byte goes to the line only at a character boundary, and only while the far end grants permission on the clear-to-send input.

Flow control needs no software. The block drives the request-to-send output from the receive fill level, so the remote sender is held off before the queue overflows. A single interrupt line tells the host when work is waiting. It fires when the receive fill reaches a selectable trigger level, or when a few bytes have sat below that level for four character times with no activity. It also fires, if enabled, when the transmit queue runs dry.

A character-time strobe, `char_tick`, stands in for the baud generator. Every character on the line occupies the span from one tick to the next.

Top module: `uart_flow_fifo`

## Requirements
- R1: After reset both fill counts are 0. `rts` is 1, while `overrun`, `tx_busy` and `tx_start` are 0. With the transmit-empty interrupt disabled, `irq` is 0 and `irq_id` is 00.
- R2: The receive FIFO holds 16 bytes and returns them in arrival order. `host_rdata` shows the oldest byte, and a cycle with `host_rd` high removes it. A read of an empty FIFO changes nothing.
- R3: A byte that arrives while the receive fill is 16 is discarded and sets `overrun`, even if a read happens in the same cycle. `overrun` stays set until a cycle with `stat_rd` high, and a new overrun in that same cycle wins.
- R4: The trigger level comes from `trig_sel`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. A receive-level cause is pending while the fill is at or above the trigger level.
- R5: `rts` is 1 exactly when the receive fill is at or below the trigger level. It drops when the fill reaches trigger+1 and returns when the fill falls back to the trigger level.
- R6: While the receive fill is between 1 and trigger-1, the fourth `char_tick` with no received byte and no host read raises the timeout cause. A received byte or a read restarts the count. A host read clears the timeout cause.
- R7: At a `char_tick` with `cts` high and the transmit FIFO non-empty, the oldest byte is removed. In the next cycle `tx_start` pulses for one cycle and `tx_data` holds that byte. Without `cts` the byte stays queued. A host write to a full 16-entry transmit FIFO is dropped.
- R8: `tx_busy` stays high from a character's start until the next `char_tick`, whatever `cts` does in between.
- R9: `irq` is high while any enabled cause is pending. `irq_id` names the highest-ranked one: 10 for receive level, then 11 for timeout (both enabled by `ie_rx`), then 01 for transmit FIFO empty (enabled by `ie_tx`), and 00 for none.
- R10: A cycle with `fifo_reset` high empties both FIFOs and clears the timeout timer and the timeout cause. It leaves `overrun` and a character already in progress untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_tick | input | 1 | One pulse per character time |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| host_rd | input | 1 | Host pops the receive FIFO |
| host_rdata | output | 8 | Oldest receive byte |
| rx_count | output | 5 | Receive fill level |
| stat_rd | input | 1 | Host status read, clears overrun |
| overrun | output | 1 | Sticky receive overrun flag |
| host_wr | input | 1 | Host pushes a transmit byte |
| host_wdata | input | 8 | Transmit byte from host |
| tx_count | output | 5 | Transmit fill level |
| fifo_reset | input | 1 | Clears both FIFOs and the timeout |
| trig_sel | input | 2 | Receive trigger level select |
| ie_rx | input | 1 | Enable for receive level and timeout interrupts |
| ie_tx | input | 1 | Enable for the transmit-empty interrupt |
| cts | input | 1 | Clear-to-send from the far end |
| rts | output | 1 | Request-to-send to the far end |
| tx_start | output | 1 | Pulse: a character starts |
| tx_data | output | 8 | Byte of the current character |
| tx_busy | output | 1 | Character in progress |
| irq | output | 1 | Host interrupt |
| irq_id | output | 2 | Highest-ranked pending cause |

## Verification
Random mixes of arrivals, reads and status reads run against a queue model, with the trigger level changed along the way. These runs separate correct ordering and fill counting from off-by-one errors at the full boundary, and they check that the `rts` threshold follows each trigger setting. Directed tick sequences count character times exactly to the fourth tick, which tells a correct restart on a byte or a read apart from a timer that keeps running. Toggling `cts` between ticks shows that permission is sampled only at boundaries and that a running character is never cut short. Enable combinations with several causes pending at once fix the interrupt ranking.

// File: rtl/uart_ff_pkg.sv
package uart_ff_pkg;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'b00,
        IRQ_TXE  = 2'b01,
        IRQ_LVL  = 2'b10,
        IRQ_TMO  = 2'b11
    } irq_id_e;

    // receive trigger level for a select code, scaled to the FIFO depth
    function automatic int trig_level(logic [1:0] sel, int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/ff_queue.sv
module ff_queue #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  logic [DW-1:0]            din,
    input  logic                     pop,
    output logic [DW-1:0]            dout,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } q_st_t;

    q_st_t st_d, st_q;
    logic  do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != FULL);
        do_pop  = pop && (st_q.cnt != '0);
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp           = st_q.wp + 1'b1;
            end
            if (do_pop) begin
                st_d.rp = st_q.rp + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL); // R2

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
    parameter int TO_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic restart,
    input  logic rd,
    input  logic tick,
    input  logic below,
    output logic expired
);
    localparam int TW = $clog2(TO_CHARS + 1);
    localparam logic [TW-1:0] LAST = TW'(TO_CHARS - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          flag;
    } tm_st_t;

    tm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr || restart || !below) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.flag = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (clr || rd) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired = st_q.flag;

    AST_TO_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(below) && $past(tick)); // R6

endmodule

// File: rtl/tx_cts_gate.sv
module tx_cts_gate #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cts,
    input  logic          avail,
    input  logic [DW-1:0] din,
    output logic          pop,
    output logic          start,
    output logic [DW-1:0] dout,
    output logic          busy
);
    typedef struct packed {
        logic          busy;
        logic          start;
        logic [DW-1:0] data;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        pop        = tick && cts && avail;
        st_d.start = pop;
        if (tick) st_d.busy = pop;
        if (pop)  st_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start = st_q.start;
    assign dout  = st_q.data;
    assign busy  = st_q.busy;

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !tick |=> busy); // R8

endmodule

// File: rtl/uart_flow_fifo.sv
module uart_flow_fifo
    import uart_ff_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    parameter int TO_CHARS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   char_tick,
    input  logic                   rx_valid,
    input  logic [DW-1:0]          rx_data,
    input  logic                   host_rd,
    output logic [DW-1:0]          host_rdata,
    output logic [$clog2(DEPTH):0] rx_count,
    input  logic                   stat_rd,
    output logic                   overrun,
    input  logic                   host_wr,
    input  logic [DW-1:0]          host_wdata,
    output logic [$clog2(DEPTH):0] tx_count,
    input  logic                   fifo_reset,
    input  logic [1:0]             trig_sel,
    input  logic                   ie_rx,
    input  logic                   ie_tx,
    input  logic                   cts,
    output logic                   rts,
    output logic                   tx_start,
    output logic [DW-1:0]          tx_data,
    output logic                   tx_busy,
    output logic                   irq,
    output logic [1:0]             irq_id
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic ovr;
    } top_st_t;

    top_st_t       st_d, st_q;
    logic [CW-1:0] trig;
    logic          lvl_hit, below, tmo, txe, tx_pop;
    logic [DW-1:0] tx_head;
    irq_id_e       id;

    ff_queue #(.DEPTH(DEPTH), .DW(DW)) rx_q_i (
        .clk(clk), .rst_n(rst_n), .clr(fifo_reset),
        .push(rx_valid), .din(rx_data), .pop(host_rd),
        .dout(host_rdata), .count(rx_count)
    );

    ff_queue #(.DEPTH(DEPTH), .DW(DW)) tx_q_i (
        .clk(clk), .rst_n(rst_n), .clr(fifo_reset),
        .push(host_wr), .din(host_wdata), .pop(tx_pop),
        .dout(tx_head), .count(tx_count)
    );

    rx_idle_timer #(.TO_CHARS(TO_CHARS)) timer_i (
        .clk(clk), .rst_n(rst_n), .clr(fifo_reset),
        .restart(rx_valid || host_rd), .rd(host_rd),
        .tick(char_tick), .below(below), .expired(tmo)
    );

    tx_cts_gate #(.DW(DW)) gate_i (
        .clk(clk), .rst_n(rst_n), .tick(char_tick), .cts(cts),
        .avail(tx_count != '0), .din(tx_head), .pop(tx_pop),
        .start(tx_start), .dout(tx_data), .busy(tx_busy)
    );

    always_comb begin
        trig    = CW'(trig_level(trig_sel, DEPTH));
        lvl_hit = rx_count >= trig;
        below   = (rx_count != '0) && (rx_count < trig);
        txe     = tx_count == '0;
        rts     = rx_count <= trig;

        st_d = st_q;
        if (stat_rd)                       st_d.ovr = 1'b0;
        if (rx_valid && rx_count == FULL)  st_d.ovr = 1'b1;

        if (ie_rx && lvl_hit)  id = IRQ_LVL;
        else if (ie_rx && tmo) id = IRQ_TMO;
        else if (ie_tx && txe) id = IRQ_TXE;
        else                   id = IRQ_NONE;
        irq    = id != IRQ_NONE;
        irq_id = id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overrun = st_q.ovr;

    AST_TX_CTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_start) |-> $past(cts) && $past(char_tick)); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !stat_rd |=> overrun); // R3

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count == FULL && !host_rd && !fifo_reset |=> rx_count == FULL); // R3

    AST_EMPTY_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count == '0 && !rx_valid |=> rx_count == '0); // R2

    AST_FIFO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_reset |=> rx_count == '0 && tx_count == '0 && !tmo); // R10

endmodule

// File: tb/uart_flow_fifo_tb_top.sv
`timescale 1ns/1ps
module uart_flow_fifo_tb_top;
    logic       clk = 0, rst_n = 0;
    logic       char_tick = 0, rx_valid = 0, host_rd = 0, stat_rd = 0;
    logic       host_wr = 0, fifo_reset = 0, ie_rx = 1, ie_tx = 0, cts = 0;
    logic [7:0] rx_data = 0, host_wdata = 0;
    logic [1:0] trig_sel = 2'b01;
    logic [7:0] host_rdata, tx_data;
    logic [4:0] rx_count, tx_count;
    logic       overrun, rts, tx_start, tx_busy, irq;
    logic [1:0] irq_id;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] mq[$];
    bit mov;

    always #4 clk = ~clk;

    uart_flow_fifo dut_i (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int trig_of(logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic cyc();
        @(posedge clk); #2;
    endtask
    task automatic push_rx(logic [7:0] b);
        rx_valid = 1; rx_data = b; cyc(); rx_valid = 0;
    endtask
    task automatic rd1();
        host_rd = 1; cyc(); host_rd = 0;
    endtask
    task automatic tick();
        char_tick = 1; cyc(); char_tick = 0;
    endtask
    task automatic wr_tx(logic [7:0] b);
        host_wr = 1; host_wdata = b; cyc(); host_wr = 0;
    endtask
    task automatic frst();
        fifo_reset = 1; cyc(); fifo_reset = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) cyc();
        rst_n = 1; cyc();
        // R1 reset state
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rts", rts, 1);
        chk("R1 overrun", overrun, 0);
        chk("R1 tx_busy", tx_busy, 0);
        chk("R1 tx_start", tx_start, 0);
        chk("R1 irq", irq, 0);
        chk("R1 irq_id", irq_id, 0);

        // R2 read of empty FIFO
        rd1();
        chk("R2 empty read", rx_count, 0);

        // R4 / R5 level and rts at trigger 4
        trig_sel = 2'b01;
        push_rx(8'd10); push_rx(8'd11); push_rx(8'd12);
        chk("R4 below level irq", irq, 0);
        chk("R5 rts at 3", rts, 1);
        push_rx(8'd13);
        chk("R4 level id", irq_id, 2);
        chk("R4 level irq", irq, 1);
        chk("R5 rts at trigger", rts, 1);
        push_rx(8'd14);
        chk("R5 rts at trigger+1", rts, 0);
        for (int i = 0; i < 5; i++) begin
            chk("R2 order", host_rdata, 10 + i);
            rd1();
        end
        chk("R2 drained", rx_count, 0);
        chk("R5 rts after drain", rts, 1);

        // R4 trigger select sweep with 8 bytes
        for (int i = 0; i < 8; i++) push_rx(8'(i));
        trig_sel = 2'b11; #1;
        chk("R4 sel 14 not hit", irq, 0);
        chk("R5 rts sel 14", rts, 1);
        trig_sel = 2'b10; #1;
        chk("R4 sel 8 hit", irq_id, 2);
        chk("R5 rts sel 8", rts, 1);
        trig_sel = 2'b00; #1;
        chk("R4 sel 1 hit", irq_id, 2);
        chk("R5 rts sel 1", rts, 0);
        frst();
        chk("R10 rx emptied", rx_count, 0);

        // R6 timeout
        trig_sel = 2'b01;
        push_rx(8'h41); push_rx(8'h42);
        tick(); tick(); tick();
        chk("R6 three ticks", irq_id, 0);
        tick();
        chk("R6 fourth tick id", irq_id, 3);
        chk("R6 fourth tick irq", irq, 1);
        rd1();
        chk("R6 cleared by read", irq_id, 0);
        tick(); tick();
        push_rx(8'h43);
        tick(); tick(); tick();
        chk("R6 restart on byte", irq_id, 0);
        tick();
        chk("R6 after restart", irq_id, 3);
        frst();
        chk("R10 timeout cleared", irq_id, 0);
        push_rx(8'h44);
        tick(); tick(); tick();
        chk("R10 timer cleared", irq_id, 0);
        frst();

        // R3 overrun
        trig_sel = 2'b11;
        for (int i = 0; i < 16; i++) push_rx(8'(8'h20 + i));
        chk("R3 full", rx_count, 16);
        chk("R3 no overrun yet", overrun, 0);
        push_rx(8'hFF);
        chk("R3 overrun set", overrun, 1);
        chk("R3 count kept", rx_count, 16);
        chk("R3 head kept", host_rdata, 8'h20);
        cyc();
        chk("R3 sticky", overrun, 1);
        stat_rd = 1; cyc(); stat_rd = 0;
        chk("R3 cleared", overrun, 0);
        rx_valid = 1; rx_data = 8'hFE; host_rd = 1; cyc(); rx_valid = 0; host_rd = 0;
        chk("R3 drop with read", overrun, 1);
        chk("R3 drop with read count", rx_count, 15);
        frst();
        chk("R10 overrun kept", overrun, 1);
        chk("R10 count", rx_count, 0);
        stat_rd = 1; cyc(); stat_rd = 0;

        // R7 / R8 / R9 transmit
        ie_tx = 1; cts = 0; #1;
        chk("R9 tx empty id", irq_id, 1);
        wr_tx(8'hA1); wr_tx(8'hA2);
        chk("R7 tx_count", tx_count, 2);
        chk("R9 no cause", irq, 0);
        tick();
        chk("R7 held by cts", tx_start, 0);
        chk("R7 held count", tx_count, 2);
        cts = 1; tick();
        chk("R7 start pulse", tx_start, 1);
        chk("R7 data", tx_data, 8'hA1);
        chk("R8 busy", tx_busy, 1);
        chk("R7 popped", tx_count, 1);
        cyc();
        chk("R7 pulse ends", tx_start, 0);
        cts = 0; cyc(); cyc();
        chk("R8 busy through cts drop", tx_busy, 1);
        tick();
        chk("R8 ends at tick", tx_busy, 0);
        chk("R7 waits", tx_count, 1);
        cts = 1; tick();
        chk("R7 second data", tx_data, 8'hA2);
        chk("R9 tx empty again", irq_id, 1);
        trig_sel = 2'b00; push_rx(8'h55);
        chk("R9 level over tx", irq_id, 2);
        ie_rx = 0; #1;
        chk("R9 rx disabled", irq_id, 1);
        ie_tx = 0; #1;
        chk("R9 all disabled", irq, 0);
        ie_rx = 1;
        rd1();
        cts = 0;
        for (int i = 0; i < 17; i++) wr_tx(8'(i));
        chk("R7 tx full drop", tx_count, 16);
        frst();
        chk("R10 tx emptied", tx_count, 0);

        // random phase: R2 R3 R5 against a queue model
        mq.delete(); mov = overrun;
        for (int n = 0; n < 600; n++) begin
            logic v, r, s;
            int sz;
            if (n % 60 == 0) trig_sel = 2'($urandom);
            v = ($urandom % 3) != 0;
            r = ($urandom % 4) == 0;
            s = ($urandom % 16) == 0;
            rx_valid = v; rx_data = 8'($urandom); host_rd = r; stat_rd = s;
            sz = mq.size();
            if (r && sz > 0) begin
                chk("R2 random head", host_rdata, mq[0]);
            end
            if (s) mov = 0;
            if (v && sz == 16) mov = 1;
            if (r && sz > 0) void'(mq.pop_front());
            if (v && sz < 16) mq.push_back(rx_data);
            cyc();
            rx_valid = 0; host_rd = 0; stat_rd = 0;
            chk("R2 random count", rx_count, mq.size());
            chk("R3 random overrun", overrun, mov);
            chk("R5 random rts", rts, (mq.size() <= trig_of(trig_sel)) ? 1 : 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule